// File: doc/BRIEF.md
# Scanline Sprite Preselector

This block picks, once per display line, the sprites that cover the line being prepared. A pulse on `start` latches the line number, the screen flip setting, the sprite bank and the palette bank. The block then reads a bank of 128 four-byte sprite entries in ascending order through a one-cycle-latency read port that is 32 bits wide. It tests each entry against the line and emits one decoded record for every sprite that covers the line. The records go to the line buffer that the renderer fills during horizontal blank.

One packed word holds each entry: byte 0 (bits 7:0) is the vertical position, byte 1 (bits 15:8) is the tile code with vertical mirroring in bit 7, byte 2 (bits 23:16) holds attributes with horizontal mirroring in bit 7, a code-bank bit in bit 6 and the colour in bits 3:0, and byte 3 (bits 31:24) is the horizontal position. At most 16 sprites are accepted per line. All arithmetic wraps at 8 bits, so sprites wrap across the screen edges and are never clipped. `done` rises when the scan is over.

Top module: `sprite_line_select`

## Requirements
- R1: After reset `done`, `spr_valid` and `ram_en` are 0 until the first `start`.
- R2: With `flip`=0, an entry is accepted when bits 7:4 of (ypos + 0xFA + line) mod 256 are all ones.
- R3: With `flip`=1, an entry is accepted when bits 7:4 of (ypos + 0xF8 + (line XOR 0xFF)) mod 256 are all ones.
- R4: `spr_row` is bits 3:0 of the same sum used for the match test.
- R5: `spr_code` is (byte1 AND 0x7F) + ((byte2 AND BANK_MASK) << BANK_SHIFT), with defaults 0x40 and 1, mod 256.
- R6: `spr_colour` is byte2 bits 3:0 plus 16 times `pal_bank`.
- R7: With `flip`=0, `spr_x` is (byte3 + 0xF8) mod 256 and `spr_flipx` is byte2 bit 7.
- R8: With `flip`=1, `spr_x` is (NOT((byte3 + 0xF8) mod 256) − 15) mod 256 and `spr_flipx` is the inverse of byte2 bit 7. `spr_flipy` is byte1 bit 7 in both modes.
- R9: No more than 16 records are emitted per scan, and entries after the 16th match produce no record.
- R10: `ram_addr` is {latched bank, entry index}, so a scan reads only entries bank*128 to bank*128+127.
- R11: `done` rises after the last entry has been tested or after the 16th accept. It stays high until the next `start`, which clears it. A `start` during a scan abandons that scan.
- R12: Records come out in ascending entry order, with `spr_slot` counting 0, 1, 2 and so on from each `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a line scan |
| line | input | 8 | Line number, latched on start |
| flip | input | 1 | Screen flip setting, latched on start |
| spr_bank | input | 1 | Sprite bank, latched on start |
| pal_bank | input | 2 | Palette bank, latched on start |
| ram_en | output | 1 | Read enable to the sprite RAM |
| ram_addr | output | 8 | Entry address {bank, index} |
| ram_rdata | input | 32 | Entry word, valid the cycle after ram_en |
| spr_valid | output | 1 | One record is valid this cycle |
| spr_slot | output | 4 | Record number within the line |
| spr_code | output | 8 | Tile code |
| spr_colour | output | 6 | Colour including palette bank |
| spr_flipx | output | 1 | Horizontal mirroring |
| spr_flipy | output | 1 | Vertical mirroring |
| spr_x | output | 8 | Horizontal start position |
| spr_row | output | 4 | Row of the sprite on this line |
| done | output | 1 | Scan complete |

## Verification
The 16-sprite cutoff and the end of the entry table can land on the same cycle. The bench sets this up by filling a bank so that exactly the last 16 entries match. It then checks that all 16 records come out, that no 17th record appears, and that `done` rises only once. A restart can also arrive while a read is still in flight. The bench pulses `start` a few cycles into a scan and the scoreboard requires that only the second scan's records appear.

// File: rtl/sprite_line_select.sv
module sprite_line_select #(
  parameter int MAX_SPR    = 16,
  parameter int ENTRIES    = 128,
  parameter int BANK_W     = 1,
  parameter int PAL_W      = 2,
  parameter int CODE_W     = 8,
  parameter logic [7:0] BANK_MASK = 8'h40,
  parameter int BANK_SHIFT = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [7:0]                      line,
  input  logic                            flip,
  input  logic [BANK_W-1:0]               spr_bank,
  input  logic [PAL_W-1:0]                pal_bank,
  output logic                            ram_en,
  output logic [BANK_W+$clog2(ENTRIES)-1:0] ram_addr,
  input  logic [31:0]                     ram_rdata,
  output logic                            spr_valid,
  output logic [$clog2(MAX_SPR)-1:0]      spr_slot,
  output logic [CODE_W-1:0]               spr_code,
  output logic [PAL_W+3:0]                spr_colour,
  output logic                            spr_flipx,
  output logic                            spr_flipy,
  output logic [7:0]                      spr_x,
  output logic [3:0]                      spr_row,
  output logic                            done
);
  localparam int IDX_W  = $clog2(ENTRIES) + 1;
  localparam int CNT_W  = $clog2(MAX_SPR + 1);
  localparam int SLOT_W = $clog2(MAX_SPR);

  logic [7:0]        line_q;
  logic              flip_q;
  logic [BANK_W-1:0] bank_q;
  logic [PAL_W-1:0]  pal_q;
  logic              busy, req_valid;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt;

  logic [7:0] ypos, b1, b2, b3;
  assign ypos = ram_rdata[7:0];
  assign b1   = ram_rdata[15:8];
  assign b2   = ram_rdata[23:16];
  assign b3   = ram_rdata[31:24];

  logic [7:0] vsum, xbase, xpos;
  logic [15:0] code_full;
  logic full, issue, hit;

  assign vsum  = flip_q ? (ypos + 8'hF8 + ~line_q) : (ypos + 8'hFA + line_q);
  assign xbase = b3 + 8'hF8;
  assign xpos  = flip_q ? (~xbase - 8'd15) : xbase;
  assign code_full = {9'd0, b1[6:0]} + ({8'd0, b2 & BANK_MASK} << BANK_SHIFT);

  assign full  = (cnt == CNT_W'(MAX_SPR));
  assign issue = busy && !idx[IDX_W-1] && !full;
  assign hit   = req_valid && !full && (vsum[7:4] == 4'hF);

  assign ram_en   = issue;
  assign ram_addr = {bank_q, idx[IDX_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; req_valid <= 1'b0; done <= 1'b0;
      idx <= '0; cnt <= '0; spr_valid <= 1'b0;
      line_q <= '0; flip_q <= 1'b0; bank_q <= '0; pal_q <= '0;
    end else if (start) begin
      busy <= 1'b1; req_valid <= 1'b0; done <= 1'b0;
      idx <= '0; cnt <= '0; spr_valid <= 1'b0;
      line_q <= line; flip_q <= flip; bank_q <= spr_bank; pal_q <= pal_bank;
    end else begin
      req_valid <= issue;
      if (issue) idx <= idx + 1'b1;
      spr_valid <= hit;
      if (hit) cnt <= cnt + 1'b1;
      if (busy && !issue && !req_valid) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit) begin
      spr_slot   <= cnt[SLOT_W-1:0];
      spr_code   <= code_full[CODE_W-1:0];
      spr_colour <= {pal_q, b2[3:0]};
      spr_flipx  <= b2[7] ^ flip_q;
      spr_flipy  <= b1[7];
      spr_x      <= xpos;
      spr_row    <= vsum[3:0];
    end
  end

  // R9
  cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_SPR));
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);
  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !done && !spr_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !ram_en && !spr_valid);
  // R9
  full_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !ram_en);
endmodule

// File: tb/sprite_line_select_tb_top.sv
module sprite_line_select_tb_top;
  logic clk = 0, rst = 1, start = 0, flip = 0, spr_bank = 0;
  logic [7:0] line = 0;
  logic [1:0] pal_bank = 0;
  logic ram_en, spr_valid, spr_flipx, spr_flipy, done;
  logic [7:0] ram_addr, spr_code, spr_x;
  logic [31:0] ram_rdata;
  logic [3:0] spr_slot, spr_row;
  logic [5:0] spr_colour;
  logic [31:0] mem [256];
  logic [31:0] expq [$];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sprite_line_select dut_i (
    .clk(clk), .rst(rst), .start(start), .line(line), .flip(flip),
    .spr_bank(spr_bank), .pal_bank(pal_bank), .ram_en(ram_en),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .spr_valid(spr_valid),
    .spr_slot(spr_slot), .spr_code(spr_code), .spr_colour(spr_colour),
    .spr_flipx(spr_flipx), .spr_flipy(spr_flipy), .spr_x(spr_x),
    .spr_row(spr_row), .done(done));

  always @(posedge clk) if (ram_en) ram_rdata <= mem[ram_addr];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R12 scoreboard monitor; fields checked cover R2..R8
  always @(negedge clk) begin
    if (!rst && spr_valid) begin
      logic [31:0] act;
      act = {spr_slot, spr_code, spr_colour, spr_flipx, spr_flipy, spr_x, spr_row};
      if (expq.size() == 0) check(0, "R9 extra record", act, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(act == e, "R2-record R12", act, e);
      end
    end
  end

  // driver: builds the expected list from the requirements
  task automatic build(input int ln, input bit fl, input int bk, input int pal);
    int n = 0;
    expq.delete();
    for (int i = 0; i < 128; i++) begin
      logic [31:0] w;
      int s, xb, x, code;
      w = mem[bk*128 + i];
      if (fl) s = (w[7:0] + 248 + (ln ^ 255)) % 256;   // R3
      else    s = (w[7:0] + 250 + ln) % 256;           // R2
      if ((s / 16) == 15 && n < 16) begin              // R9
        xb = (w[31:24] + 248) % 256;                   // R7
        x  = fl ? ((255 - xb) - 15 + 256) % 256 : xb;  // R8
        code = (w[14:8] + (w[22] ? 128 : 0)) % 256;    // R5
        expq.push_back({4'(n), 8'(code), 2'(pal), w[19:16], w[23] ^ fl, w[15],
                        8'(x), 4'(s % 16)});           // R4 R6
        n++;
      end
    end
  endtask

  task automatic pulse(input int ln, input bit fl, input int bk, input int pal);
    @(negedge clk);
    line = 8'(ln); flip = fl; spr_bank = bk[0]; pal_bank = 2'(pal); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run(input int ln, input bit fl, input int bk, input int pal, input string tag);
    int t = 0;
    build(ln, fl, bk, pal);
    pulse(ln, fl, bk, pal);
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(t < 2000, "R11 watchdog", t, 2000);
    @(negedge clk);
    check(expq.size() == 0, {tag, " all records seen"}, expq.size(), 0);
    repeat (3) @(negedge clk);
    check(done == 1, "R11 done holds", done, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    mem[0][31:24] = 8'h08; mem[1][31:24] = 8'h07; mem[2][31:24] = 8'hFF;
    repeat (3) @(negedge clk);
    check(done == 0 && spr_valid == 0 && ram_en == 0, "R1 reset", {done, spr_valid, ram_en}, 0);
    rst = 0;
    @(negedge clk);
    check(done == 0 && ram_en == 0, "R1 idle", {done, ram_en}, 0);
    for (int l = 0; l < 6; l++) run(l * 37 + 3, 0, 0, l % 4, "R2 R7 unflipped");
    for (int l = 0; l < 6; l++) run(l * 41 + 9, 1, 0, 3 - l % 4, "R3 R8 flipped");
    // R9 R10: bank 1, every entry matches
    for (int k = 0; k < 128; k++) mem[128 + k][7:0] = 8'((k % 16) - 10 - 50);
    run(50, 0, 1, 1, "R9 cutoff R10 bank");
    // R11 coincident: only the last 16 entries of bank 1 match
    for (int k = 0; k < 128; k++)
      mem[128 + k][7:0] = (k >= 112) ? 8'((k % 16) - 10 - 50) : 8'(6 - 50);
    run(50, 0, 1, 2, "R11 last entry is 16th");
    // R11 restart during a scan
    pulse(50, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(done == 0, "R11 busy", done, 0);
    run(77, 1, 0, 1, "R11 restart");
    if (spr_valid) check(0, "R11 late record", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule